// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the synchronous control front end of a burst-capable cache memory. On every rising clock edge it samples an external address, two active-low burst-start strobes (one meant for a processor, one for a cache controller), an active-low advance input, three chip selects and an active-low write indication. From these it keeps a registered memory address, a selected flag and an operation code that the storage core behind it consumes.

A burst begins by loading the external address. After that, the low two address bits run through four positions driven by an internal 2-bit counter. A static order input picks either a plain incrementing order or an XOR-based interleaved order. The counter steps when advance is low and holds when advance is high. The two strobes have different chip-select gating. The processor strobe is dropped completely while the primary select is inactive. The controller strobe still acts while the primary select is inactive, and in that case it turns the device off.

Top module: `burst_seq_top`

## Requirements
- R1: A load cycle happens when `start_proc_n` is low with `sel_pri_n` low, or when `start_ctrl_n` is low. If all three selects are valid at that point (`sel_pri_n`=0, `sel_hi`=1, `sel_lo_n`=0), then one cycle later `active`=1 and `mem_addr` equals the sampled `addr_in`. If any select is invalid, then one cycle later `active`=0 and `op_code`=00.
- R2: While `sel_pri_n`=1, a low `start_proc_n` has no effect. In that case a low `start_ctrl_n` deselects the device (`active`=0, `op_code`=00).
- R3: A burst started through `start_proc_n` is always a read (`op_code`=01), whatever `wr_n` is.
- R4: A burst started through `start_ctrl_n` while `start_proc_n` is high is a read (01) when `wr_n`=1 and a write (10) when `wr_n`=0.
- R5: The level of `adv_n` on a load edge has no effect: the first address is always the loaded one.
- R6: When both strobes are high and the device is active, `adv_n`=0 moves the burst to its next address. `op_code` then follows `wr_n` (1 gives 01, 0 gives 10).
- R7: When both strobes are high, the device is active and `adv_n`=1, the address is held and `op_code` follows `wr_n` as in R6.
- R8: With `order_xor`=0, `mem_addr[1:0]` equals (start bits + count) modulo 4.
- R9: With `order_xor`=1, `mem_addr[1:0]` equals (start bits XOR count).
- R10: After the fourth address of a burst, one more advance returns to the start address.
- R11: The selects are sampled only on load cycles. Continue and suspend cycles keep the selection of their burst. While deselected with both strobes high, `active` stays 0 and `op_code` stays 00.
- R12: `mem_addr` bits above bit 1 keep their loaded value for the whole burst.
- R13: While reset is applied, and after it, `active`=0, `op_code`=00 and `mem_addr`=0 until the first load cycle. `op_code` is 00 whenever `active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External start address |
| start_proc_n | input | 1 | Processor burst-start strobe, active low |
| start_ctrl_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_pri_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Expansion select, active high |
| sel_lo_n | input | 1 | Expansion select, active low |
| wr_n | input | 1 | Write indication, low means write |
| order_xor | input | 1 | Static order: 0 incrementing, 1 interleaved |
| mem_addr | output | ADDR_W | Current memory address |
| active | output | 1 | Device selected for the current cycle |
| op_code | output | 2 | 00 none, 01 read, 10 write |

## Verification
The assertions take `order_xor` to be static while a burst runs. Wherever an address relation depends on it, they accept a cycle in which it changed. They also expect reset to be low from time zero so that no history is taken from before reset. The stimulus changes the order input only between its two long random phases, and it drives every input half a cycle away from the sampling edge. The random mix favours high strobes so that continue and suspend runs are long, and it sometimes drops single selects so that the deselect paths of both strobes are reached.

// File: rtl/burst_seq_pkg.sv
// Package: shared command and operation encodings of the burst sequencer.
// Assumes: nothing; types only.
package burst_seq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_STEP  = 2'b01,
        CMD_LOAD  = 2'b10,
        CMD_DESEL = 2'b11
    } burst_cmd_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } mem_op_e;
endpackage

// File: rtl/burst_cmd_decode.sv
// Module: turns the sampled strobes, selects and advance into one command
// per cycle, and gives the operation to use when a burst is loaded.
// Assumes: all inputs are stable around the rising clock edge.
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       start_proc_n,
    input  logic       start_ctrl_n,
    input  logic       adv_n,
    input  logic       sel_pri_n,
    input  logic       sel_hi,
    input  logic       sel_lo_n,
    input  logic       wr_n,
    output burst_cmd_e cmd,
    output mem_op_e    load_op
);
    logic sel_ok;
    logic proc_take;

    // Purpose: full selection and processor-strobe qualification.
    always_comb begin
        sel_ok    = !sel_pri_n && sel_hi && !sel_lo_n;
        proc_take = !start_proc_n && !sel_pri_n;
    end

    // Purpose: priority decode: processor start, controller start, continue/suspend.
    always_comb begin
        cmd     = CMD_HOLD;
        load_op = OP_READ;
        if (proc_take) begin
            cmd     = sel_ok ? CMD_LOAD : CMD_DESEL;
            load_op = OP_READ;
        end else if (!start_ctrl_n) begin
            cmd     = sel_ok ? CMD_LOAD : CMD_DESEL;
            load_op = wr_n ? OP_READ : OP_WRITE;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: holds the loaded start address and the burst counter, and forms the
// memory address with an incrementing or interleaved low field.
// Assumes: order_xor is static during a burst; load wins over step.
module burst_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    logic [ADDR_W-1:0]     start_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] lin_low;
    logic [BURST_BITS-1:0] low_bits;

    // Purpose: capture the start address and run the wrapping counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            start_q <= addr_in;
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: incrementing order, carry dropped past the burst field.
    always_comb begin
        lin_low = start_q[BURST_BITS-1:0] + cnt_q;
    end

    // Purpose: per-bit choice between incrementing and XOR order.
    for (genvar i = 0; i < BURST_BITS; i++) begin : g_low
        assign low_bits[i] = order_xor ? (start_q[i] ^ cnt_q[i]) : lin_low[i];
    end

    assign mem_addr = {start_q[ADDR_W-1 -: HI_W], low_bits};
endmodule

// File: rtl/burst_op_state.sv
// Module: selection flag and operation code register for the storage core.
// Assumes: commands come from burst_cmd_decode.
module burst_op_state
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  burst_cmd_e cmd,
    input  mem_op_e    load_op,
    input  logic       wr_n,
    output logic       active,
    output logic [1:0] op_code
);
    mem_op_e op_q;

    // Purpose: update selection and operation on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            op_q   <= OP_NONE;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    active <= 1'b1;
                    op_q   <= load_op;
                end
                CMD_DESEL: begin
                    active <= 1'b0;
                    op_q   <= OP_NONE;
                end
                default: begin
                    op_q <= active ? (wr_n ? OP_READ : OP_WRITE) : OP_NONE;
                end
            endcase
        end
    end

    assign op_code = op_q;
endmodule

// File: rtl/burst_seq_top.sv
// Module: top of the burst address sequencer; connects decode, address
// generator and operation state.
// Assumes: synchronous active-low reset; order_xor tied or static.
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_proc_n,
    input  logic              start_ctrl_n,
    input  logic              adv_n,
    input  logic              sel_pri_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              wr_n,
    input  logic              order_xor,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              active,
    output logic [1:0]        op_code
);
    burst_cmd_e cmd;
    mem_op_e    load_op;
    logic       do_load;
    logic       do_step;

    burst_cmd_decode i_decode (
        .start_proc_n (start_proc_n),
        .start_ctrl_n (start_ctrl_n),
        .adv_n        (adv_n),
        .sel_pri_n    (sel_pri_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .wr_n         (wr_n),
        .cmd          (cmd),
        .load_op      (load_op)
    );

    // Purpose: counter controls; steps only inside a selected burst.
    always_comb begin
        do_load = (cmd == CMD_LOAD);
        do_step = (cmd == CMD_STEP) && active;
    end

    burst_addr_gen #(
        .ADDR_W     (ADDR_W),
        .BURST_BITS (BURST_BITS)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .step      (do_step),
        .order_xor (order_xor),
        .addr_in   (addr_in),
        .mem_addr  (mem_addr)
    );

    burst_op_state i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .load_op (load_op),
        .wr_n    (wr_n),
        .active  (active),
        .op_code (op_code)
    );
endmodule

// File: rtl/burst_seq_checker.sv
// Module: temporal checks on the sequencer ports, bound to burst_seq_top.
// Assumes: reset low from time zero.
module burst_seq_checker #(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              start_proc_n,
    input logic              start_ctrl_n,
    input logic              adv_n,
    input logic              sel_pri_n,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              wr_n,
    input logic              order_xor,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              active,
    input logic [1:0]        op_code
);
    AST_PROC_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_proc_n && !sel_pri_n && sel_hi && !sel_lo_n) |=> (active && op_code == 2'b01)); // R3
    AST_CTRL_CS1_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ctrl_n && sel_pri_n) |=> (!active && op_code == 2'b00)); // R2
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_proc_n && start_ctrl_n && adv_n) |=> ($stable(mem_addr) || !$stable(order_xor))); // R7
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start_proc_n && start_ctrl_n && !adv_n)
        |=> (mem_addr[BURST_BITS-1:0] != $past(mem_addr[BURST_BITS-1:0]) || !$stable(order_xor))); // R6
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_proc_n && start_ctrl_n) |=> $stable(mem_addr[ADDR_W-1:BURST_BITS])); // R12
    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_proc_n && start_ctrl_n) |=> $stable(active)); // R11
    AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (op_code == 2'b00)); // R13
endmodule

bind burst_seq_top burst_seq_checker #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .start_proc_n (start_proc_n),
    .start_ctrl_n (start_ctrl_n),
    .adv_n        (adv_n),
    .sel_pri_n    (sel_pri_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .wr_n         (wr_n),
    .order_xor    (order_xor),
    .mem_addr     (mem_addr),
    .active       (active),
    .op_code      (op_code)
);

// File: tb/test_burst_seq_top.sv
module test_burst_seq_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          start_proc_n = 1'b1;
    logic          start_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          sel_pri_n = 1'b1;
    logic          sel_hi = 1'b0;
    logic          sel_lo_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          order_xor = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          active;
    logic [1:0]    op_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic          m_act = 1'b0;
    logic [1:0]    m_op  = 2'b00;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'b00;
    string         m_tag;

    always #10 clk = ~clk;

    burst_seq_top #(.ADDR_W(AW)) i_burst_seq_top (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n), .adv_n(adv_n),
        .sel_pri_n(sel_pri_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .wr_n(wr_n), .order_xor(order_xor),
        .mem_addr(mem_addr), .active(active), .op_code(op_code)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic [1:0] cnt, logic ox);
        logic [1:0] lo;
        lo = ox ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
        return {base[AW-1:2], lo};
    endfunction

    // predict model state from the inputs sampled at the coming edge
    task automatic predict();
        logic ok;
        ok = !sel_pri_n && sel_hi && !sel_lo_n;
        if (!start_proc_n && !sel_pri_n) begin
            if (ok) begin m_act = 1; m_op = 2'b01; m_base = addr_in; m_cnt = 0; m_tag = "R3"; end
            else begin m_act = 0; m_op = 2'b00; m_tag = "R1"; end
        end else if (!start_ctrl_n) begin
            if (sel_pri_n) begin m_act = 0; m_op = 2'b00; m_tag = "R2"; end
            else if (ok) begin m_act = 1; m_op = wr_n ? 2'b01 : 2'b10; m_base = addr_in; m_cnt = 0; m_tag = "R4"; end
            else begin m_act = 0; m_op = 2'b00; m_tag = "R1"; end
        end else if (m_act) begin
            m_op = wr_n ? 2'b01 : 2'b10;
            if (!adv_n) begin m_cnt = m_cnt + 1; m_tag = order_xor ? "R6 R9" : "R6 R8"; end
            else m_tag = "R7";
        end else begin
            m_op = 2'b00; m_tag = "R11";
        end
    endtask

    task automatic compare(string tag);
        logic [AW-1:0] ea;
        ea = exp_addr(m_base, m_cnt, order_xor);
        checks++;
        if (active !== m_act || op_code !== m_op || (m_act && mem_addr !== ea)) begin
            fails++;
            $display("FAIL %s: act=%0b op=%0b addr=%h expected act=%0b op=%0b addr=%h",
                     tag, active, op_code, mem_addr, m_act, m_op, ea);
        end
    endtask

    // drive at negedge, clock once, compare at next negedge
    task automatic cyc(logic p, logic c, logic a, logic s1, logic s2, logic s3, logic w,
                       logic [AW-1:0] ad, string tag);
        start_proc_n = p; start_ctrl_n = c; adv_n = a;
        sel_pri_n = s1; sel_hi = s2; sel_lo_n = s3; wr_n = w; addr_in = ad;
        predict();
        @(posedge clk);
        @(negedge clk);
        compare(tag == "" ? m_tag : tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R13: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] hi_keep;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        checks++;
        if (active !== 1'b0 || op_code !== 2'b00 || mem_addr !== '0) begin
            fails++;
            $display("FAIL R13: act=%0b op=%0b addr=%h expected 0 0 0000", active, op_code, mem_addr);
        end
        rst_n = 1'b1;
        // R13: idle after reset with strobes high
        cyc(1,1,0,0,1,0,1,16'h0, "R13");

        // R8 R10 R12: incrementing burst from low bits 2, wrap after four
        order_xor = 0;
        cyc(0,1,1,0,1,0,0,16'h1236, "R3");
        cyc(1,1,0,1,0,1,1,16'hFFFF, "R8 R11");
        cyc(1,1,0,1,0,1,1,16'h0000, "R8");
        cyc(1,1,0,0,1,0,0,16'h5555, "R8");
        hi_keep = mem_addr;
        cyc(1,1,0,0,1,0,1,16'h0000, "R10");
        checks++;
        if (mem_addr !== 16'h1236 || mem_addr[AW-1:2] !== hi_keep[AW-1:2]) begin
            fails++;
            $display("FAIL R12: addr=%h expected 1236", mem_addr);
        end

        // R9 R10: interleaved burst from low bits 3
        order_xor = 1;
        cyc(1,0,1,0,1,0,0,16'hABC7, "R4");
        cyc(1,1,0,0,1,0,0,16'h0, "R9");
        cyc(1,1,0,0,1,0,0,16'h0, "R9");
        cyc(1,1,1,0,1,0,1,16'h0, "R7");
        cyc(1,1,0,0,1,0,1,16'h0, "R9");
        cyc(1,1,0,0,1,0,1,16'h0, "R10");

        // R5: advance low on the load edge
        cyc(0,1,0,0,1,0,1,16'h0402, "R5");
        // R2: processor strobe with primary select off is ignored
        cyc(0,1,0,1,1,0,1,16'hDEAD, "R2");
        // R2: controller strobe with primary select off deselects
        cyc(1,0,1,1,1,0,1,16'hBEEF, "R2");
        cyc(1,1,0,0,1,0,0,16'h0, "R11");
        // R1: bad expansion select deselects
        cyc(1,0,1,0,1,0,1,16'h0010, "R4");
        cyc(0,1,1,0,0,0,1,16'h0020, "R1");
        // R3: processor start with write indication low still reads; wins over controller
        cyc(0,0,1,0,1,0,0,16'h0030, "R3");

        for (int ph = 0; ph < 2; ph++) begin
            order_xor = ph[0];
            for (int i = 0; i < 3000; i++) begin
                int r;
                r = $urandom;
                cyc((r % 7) != 0, ((r >> 3) % 5) != 0, (r >> 6) & 1,
                    ((r >> 7) % 6) == 0, ((r >> 10) % 9) != 0, ((r >> 14) % 9) == 0,
                    (r >> 18) & 1, AW'($urandom), "");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule